// File: doc/BRIEF.md
# GPIO-Triggered Keyboard Scan-Code Sequencer

This block turns level changes on a set of GPIO channels into a stream of keyboard scan-code bytes. A keyboard-controller path consumes that stream. Every channel has a control byte, stored at a register index equal to the channel number. The control byte can add three modifier keys and an escape pre-code around the channel's key code. It also sets the typematic timing: how long a held input waits before it starts repeating, and how fast it repeats after that. The key code for each channel comes in on a port.

Input levels are sampled synchronously. When a channel goes active, the block sends its press sequence. While the channel stays active, the block sends repeat sequences at the programmed timing. When the channel goes inactive, it sends the release sequence. The output is a byte stream with valid/ready flow control. A started sequence always finishes before the next one begins. When several channels are waiting, the lowest-numbered channel is served first. Typematic timing counts an external prescaled tick, and the counting stops while the output is held off.

Top module: `gpio_keyseq`

## Requirements
- R1: After reset, every control byte reads 0x00 and out_valid_o is low.
- R2: A write with reg_we_i stores reg_wdata_i into the control byte of channel reg_idx_i. reg_rdata_o shows, combinationally, the byte addressed by reg_idx_i.
- R3: A press sequence sends, in this order: 0x1D if bit 7 is set, 0x38 if bit 6 is set, 0x2A if bit 5 is set, 0xE0 if bit 4 is set, and then the channel's key code.
- R4: A release sequence sends the same optional 0x1D, 0x38, 0x2A and 0xE0 bytes in the same order. It then sends the break code, which is the key code OR 0x80. After that it sends modifier breaks in reverse order: 0xAA if bit 5 is set, 0xB8 if bit 6 is set, and 0x9D if bit 7 is set.
- R5: A repeat sequence sends only 0xE0 (if bit 4 is set) followed by the key code. Modifier bytes are never repeated.
- R6: The first repeat starts (bits 3:2 + 1) x 250 ticks after the press sequence ends. With a tick and ready on every cycle, the key-code bytes of the press and the first repeat are accepted 252 cycles apart for delay code 0 and 500 ticks + 3 cycles apart for delay code 1 when 0xE0 is sent. In general the gap is the tick count plus 2, plus 1 when bit 4 is set.
- R7: Bit 0 sets the gap between repeats: 0 selects 33 ticks and 1 selects 100 ticks. The same +2 / +3 cycle accounting applies.
- R8: When several channels have work pending, the lowest channel number is served first, and bytes from two sequences never interleave.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R10: Typematic counting stops in every cycle where out_valid_o is high and out_ready_i is low. Each stalled cycle lengthens a pending repeat gap by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaled timing tick, one typematic time unit per pulse |
| gpio_i | input | NCH | Synchronous channel activity levels |
| key_code_i | input | NCH*8 | Key code of each channel, channel n at bits 8n+7:8n |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_idx_i | input | CH_W | Control byte index, equal to the channel number |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte at reg_idx_i |
| out_valid_o | output | 1 | Byte available |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_data_o | output | 8 | Scan-code byte |

## Verification
The first byte of a sequence appears one clock edge after the input level changes. Each further byte follows one edge after the previous byte is accepted. The bench therefore does not check fixed cycle positions for content. It logs every accepted byte with its cycle stamp, sampled on the falling edge, and compares the whole log against sequences built from the requirements. Repeat timing is due tick count + 2 cycles after the key-code acceptance that loaded the timer, or + 3 when a pre-code comes first. The bench measures those gaps from the stamps and adds the stall cycles it counted itself. Inputs change just after the rising edge, so sampling never races an edge.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  localparam logic [7:0] KC_CTRL  = 8'h1D;
  localparam logic [7:0] KC_ALT   = 8'h38;
  localparam logic [7:0] KC_SHIFT = 8'h2A;
  localparam logic [7:0] KC_PRE   = 8'hE0;
  localparam logic [7:0] KC_BRK   = 8'h80;

  typedef enum logic [1:0] {
    SEQ_PRESS   = 2'd0,
    SEQ_REPEAT  = 2'd1,
    SEQ_RELEASE = 2'd2
  } seq_kind_e;

  // Emission slots; their numeric order is the emission order.
  typedef enum logic [2:0] {
    SL_CTRL_MK  = 3'd0,
    SL_ALT_MK   = 3'd1,
    SL_SHF_MK   = 3'd2,
    SL_PRE      = 3'd3,
    SL_KEY      = 3'd4,
    SL_SHF_BRK  = 3'd5,
    SL_ALT_BRK  = 3'd6,
    SL_CTRL_BRK = 3'd7
  } slot_e;

  typedef struct packed {
    logic       ctrl_en;
    logic       alt_en;
    logic       shift_en;
    logic       pre_en;
    logic [1:0] dly_sel;
    logic       spare;
    logic       rep_slow;
  } ctrl_t;

  function automatic logic [7:0] slot_mask(seq_kind_e k, ctrl_t c);
    logic [7:0] m;
    logic       not_rep;
    logic       rel;
    not_rep = (k != SEQ_REPEAT);
    rel     = (k == SEQ_RELEASE);
    m[0] = c.ctrl_en  & not_rep;
    m[1] = c.alt_en   & not_rep;
    m[2] = c.shift_en & not_rep;
    m[3] = c.pre_en;
    m[4] = 1'b1;
    m[5] = c.shift_en & rel;
    m[6] = c.alt_en   & rel;
    m[7] = c.ctrl_en  & rel;
    return m;
  endfunction

  // {found, index} of the lowest set mask bit at or above 'from'.
  function automatic logic [3:0] first_from(logic [7:0] m, logic [3:0] from);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 7; i >= 0; i--) begin
      if (m[i] && (4'(i) >= from)) r = {1'b1, 3'(i)};
    end
    return r;
  endfunction

  function automatic logic [7:0] slot_byte(slot_e s, seq_kind_e k, logic [7:0] code);
    logic [7:0] b;
    case (s)
      SL_CTRL_MK:  b = KC_CTRL;
      SL_ALT_MK:   b = KC_ALT;
      SL_SHF_MK:   b = KC_SHIFT;
      SL_PRE:      b = KC_PRE;
      SL_KEY:      b = (k == SEQ_RELEASE) ? (code | KC_BRK) : code;
      SL_SHF_BRK:  b = KC_SHIFT | KC_BRK;
      SL_ALT_BRK:  b = KC_ALT | KC_BRK;
      default:     b = KC_CTRL | KC_BRK;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/keyseq_timer.sv
module keyseq_timer
  import keyseq_pkg::*;
#(
  parameter int DLY_UNIT = 250,
  parameter int REP_FAST = 33,
  parameter int REP_SLOW = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       stall_i,
  input  logic       load_delay_i,
  input  logic       load_repeat_i,
  input  logic [1:0] dly_sel_i,
  input  logic       rep_slow_i,
  output logic       expired_o
);

  localparam int MAXV  = (4 * DLY_UNIT > REP_SLOW) ? 4 * DLY_UNIT : REP_SLOW;
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dly_val, rep_val;
  logic             cnt_en;

  always_comb begin
    case (dly_sel_i)
      2'd0:    dly_val = CNT_W'(DLY_UNIT);
      2'd1:    dly_val = CNT_W'(2 * DLY_UNIT);
      2'd2:    dly_val = CNT_W'(3 * DLY_UNIT);
      default: dly_val = CNT_W'(4 * DLY_UNIT);
    endcase
    rep_val = rep_slow_i ? CNT_W'(REP_SLOW) : CNT_W'(REP_FAST);
  end

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (load_delay_i) begin
      cnt_d = dly_val;
    end else if (load_repeat_i) begin
      cnt_d = rep_val;
    end else if (tick_i && !stall_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  p_timer_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i && !load_delay_i && !load_repeat_i |=> $stable(cnt_q));

  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAXV));

endmodule

// File: rtl/keyseq_arb.sv
module keyseq_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] grant_o,
  output logic           any_o
);

  // Isolate the lowest set request bit.
  assign grant_o = req_i & (~req_i + 1'b1);
  assign any_o   = |req_i;

endmodule

// File: rtl/keyseq_emit.sv
module keyseq_emit
  import keyseq_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  seq_kind_e       start_kind_i,
  input  ctrl_t           start_cfg_i,
  input  logic [7:0]      start_code_i,
  output logic            busy_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [7:0]      out_data_o,
  output logic            done_o,
  output logic [CH_W-1:0] done_ch_o,
  output seq_kind_e       done_kind_o
);

  logic            busy_q, busy_d;
  logic [CH_W-1:0] ch_q, ch_d;
  seq_kind_e       kind_q, kind_d;
  ctrl_t           cfg_q, cfg_d;
  logic [7:0]      code_q, code_d;
  slot_e           slot_q, slot_d;
  logic [3:0]      nxt, first;
  logic            fire;

  assign nxt   = first_from(slot_mask(kind_q, cfg_q), {1'b0, slot_q} + 4'd1);
  assign first = first_from(slot_mask(start_kind_i, start_cfg_i), 4'd0);
  assign fire  = busy_q && out_ready_i;

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    kind_d = kind_q;
    cfg_d  = cfg_q;
    code_d = code_q;
    slot_d = slot_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        ch_d   = start_ch_i;
        kind_d = start_kind_i;
        cfg_d  = start_cfg_i;
        code_d = start_code_i;
        slot_d = slot_e'(first[2:0]);
      end
    end else if (fire) begin
      if (nxt[3]) slot_d = slot_e'(nxt[2:0]);
      else        busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= '0;
      kind_q <= SEQ_PRESS;
      cfg_q  <= '0;
      code_q <= '0;
      slot_q <= SL_CTRL_MK;
    end else begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      kind_q <= kind_d;
      cfg_q  <= cfg_d;
      code_q <= code_d;
      slot_q <= slot_d;
    end
  end

  assign busy_o      = busy_q;
  assign out_valid_o = busy_q;
  assign out_data_o  = slot_byte(slot_q, kind_q, code_q);
  assign done_o      = fire && !nxt[3];
  assign done_ch_o   = ch_q;
  assign done_kind_o = kind_q;

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_no_interleave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_o |=> busy_q && $stable(ch_q) && $stable(kind_q));

  p_slot_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !done_o |=> slot_q > $past(slot_q));

endmodule

// File: rtl/gpio_keyseq.sv
module gpio_keyseq
  import keyseq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DLY_UNIT = 250,
  parameter int REP_FAST = 33,
  parameter int REP_SLOW = 100,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [NCH-1:0]  gpio_i,
  input  logic [NCH*8-1:0] key_code_i,
  input  logic            reg_we_i,
  input  logic [CH_W-1:0] reg_idx_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [7:0]      out_data_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // Control bytes, one per channel.
  ctrl_t ctrl_q [NCH];
  logic  wr_en;
  assign wr_en = reg_we_i && ({1'b0, reg_idx_i} < (CH_W+1)'(NCH));

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < NCH; i++) ctrl_q[i] <= '0;
    end else if (wr_en) begin
      ctrl_q[reg_idx_i] <= ctrl_t'(reg_wdata_i);
    end
  end
  assign reg_rdata_o = ctrl_q[reg_idx_i];

  // Per-channel requests and typematic timers.
  logic [NCH-1:0] down_q, down_d;
  logic [NCH-1:0] press_req, rel_req, rep_req, req;
  logic [NCH-1:0] tmr_zero, ld_dly, ld_rep, grant;
  logic           any_req, stall, busy, emit_done;
  logic [CH_W-1:0] done_ch;
  seq_kind_e      done_kind;

  assign stall = out_valid_o && !out_ready_i;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign press_req[g] = gpio_i[g] && !down_q[g];
    assign rel_req[g]   = !gpio_i[g] && down_q[g];
    assign rep_req[g]   = gpio_i[g] && down_q[g] && tmr_zero[g];
    assign req[g]       = press_req[g] || rel_req[g] || rep_req[g];
    assign ld_dly[g]    = emit_done && (done_ch == CH_W'(g)) && (done_kind == SEQ_PRESS);
    assign ld_rep[g]    = emit_done && (done_ch == CH_W'(g)) && (done_kind == SEQ_REPEAT);

    keyseq_timer #(
      .DLY_UNIT (DLY_UNIT),
      .REP_FAST (REP_FAST),
      .REP_SLOW (REP_SLOW)
    ) u_tmr (
      .clk           (clk),
      .rst_n         (rst_core_n),
      .tick_i        (tick_i),
      .stall_i       (stall),
      .load_delay_i  (ld_dly[g]),
      .load_repeat_i (ld_rep[g]),
      .dly_sel_i     (ctrl_q[g].dly_sel),
      .rep_slow_i    (ctrl_q[g].rep_slow),
      .expired_o     (tmr_zero[g])
    );
  end

  keyseq_arb #(.NCH(NCH)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any_req)
  );

  // Decode the granted channel.
  logic [CH_W-1:0] sel_ch;
  seq_kind_e       sel_kind;
  ctrl_t           sel_cfg;
  logic [7:0]      sel_code;

  always_comb begin
    sel_ch   = '0;
    sel_kind = SEQ_PRESS;
    sel_cfg  = '0;
    sel_code = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        sel_ch   = CH_W'(i);
        sel_kind = rel_req[i] ? SEQ_RELEASE : (rep_req[i] ? SEQ_REPEAT : SEQ_PRESS);
        sel_cfg  = ctrl_q[i];
        sel_code = key_code_i[i*8 +: 8];
      end
    end
  end

  keyseq_emit #(.CH_W(CH_W)) u_emit (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_i      (any_req && !busy),
    .start_ch_i   (sel_ch),
    .start_kind_i (sel_kind),
    .start_cfg_i  (sel_cfg),
    .start_code_i (sel_code),
    .busy_o       (busy),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .done_o       (emit_done),
    .done_ch_o    (done_ch),
    .done_kind_o  (done_kind)
  );

  // Key state as last reported downstream.
  always_comb begin
    down_d = down_q;
    if (emit_done) begin
      if (done_kind == SEQ_PRESS)   down_d[done_ch] = 1'b1;
      if (done_kind == SEQ_RELEASE) down_d[done_ch] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    down_q <= '0;
    else if (emit_done) down_q <= down_d;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(grant));

  p_reg_write_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |=> ctrl_q[$past(reg_idx_i)] == ctrl_t'($past(reg_wdata_i)));

  p_press_marks_down_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    emit_done && (done_kind == SEQ_PRESS) |=> down_q[$past(done_ch)]);

  p_release_clears_down_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    emit_done && (done_kind == SEQ_RELEASE) |=> !down_q[$past(done_ch)]);

endmodule

// File: tb/tb_gpio_keyseq.sv
module tb_gpio_keyseq;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick;
  logic [NCH-1:0] gpio;
  logic [NCH*8-1:0] codes;
  logic           reg_we;
  logic [1:0]     reg_idx;
  logic [7:0]     reg_wdata;
  logic [7:0]     reg_rdata;
  logic           out_valid;
  logic           out_ready;
  logic [7:0]     out_data;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  int unsigned stall_cnt = 0;
  int rdy_mode = 1;

  logic [7:0]  got_q [$];
  int unsigned got_t [$];
  logic [7:0]  exp_q [$];

  always #2 clk = ~clk;

  gpio_keyseq dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gpio_i(gpio), .key_code_i(codes),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b0;
      1:       out_ready = 1'b1;
      default: out_ready = (($urandom % 4) != 0);
    endcase
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_valid && out_ready) begin
      got_q.push_back(out_data);
      got_t.push_back(cyc);
    end
    if (rst_n && out_valid && !out_ready) stall_cnt++;
  end

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int ch, logic [7:0] v);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_idx = 2'(ch); reg_wdata = v;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // kind: 0 press, 1 repeat, 2 release
  task automatic push_exp(int kind, logic [7:0] cfg, logic [7:0] code);
    if (kind != 1) begin
      if (cfg[7]) exp_q.push_back(8'h1D);
      if (cfg[6]) exp_q.push_back(8'h38);
      if (cfg[5]) exp_q.push_back(8'h2A);
    end
    if (cfg[4]) exp_q.push_back(8'hE0);
    exp_q.push_back((kind == 2) ? (code | 8'h80) : code);
    if (kind == 2) begin
      if (cfg[5]) exp_q.push_back(8'hAA);
      if (cfg[6]) exp_q.push_back(8'hB8);
      if (cfg[7]) exp_q.push_back(8'h9D);
    end
  endtask

  task automatic compare_stream(string r);
    int n;
    chk(got_q.size() == exp_q.size(), {r, " stream length"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] == exp_q[i], {r, " stream byte"}, got_q[i], exp_q[i]);
    got_q.delete(); got_t.delete(); exp_q.delete();
  endtask

  function automatic int count_of(logic [7:0] k);
    int c = 0;
    foreach (got_q[i]) if (got_q[i] == k) c++;
    return c;
  endfunction

  function automatic int unsigned time_of(logic [7:0] k, int nth);
    int c = 0;
    foreach (got_q[i]) begin
      if (got_q[i] == k) begin
        if (c == nth) return got_t[i];
        c++;
      end
    end
    return 0;
  endfunction

  task automatic wait_count(logic [7:0] k, int n);
    for (int i = 0; i < 3000 && count_of(k) < n; i++) cycles(1);
  endtask

  task automatic typematic(int ch, logic [7:0] cfg, logic [7:0] k, int d_ticks, int r_ticks, string rd, string rr);
    int extra;
    int unsigned t0, t1, t2, t3;
    extra = cfg[4] ? 3 : 2;
    rdy_mode = 1;
    wr(ch, cfg);
    codes[ch*8 +: 8] = k;
    gpio[ch] = 1'b1;
    wait_count(k, 4);
    gpio[ch] = 1'b0;
    cycles(40);
    t0 = time_of(k, 0); t1 = time_of(k, 1); t2 = time_of(k, 2); t3 = time_of(k, 3);
    chk(int'(t1 - t0) == d_ticks + extra, rd, int'(t1 - t0), d_ticks + extra);
    chk(int'(t2 - t1) == r_ticks + extra, rr, int'(t2 - t1), r_ticks + extra);
    chk(int'(t3 - t2) == r_ticks + extra, rr, int'(t3 - t2), r_ticks + extra);
    push_exp(0, cfg, k);
    for (int i = 0; i < 3; i++) push_exp(1, cfg, k);
    push_exp(2, cfg, k);
    compare_stream("R5 repeat content");
    wr(ch, 8'h00);
  endtask

  task automatic run_all();
    logic [7:0] cfg, code;
    int ch;
    logic [7:0] hold_b;
    int unsigned ta, tb;
    int st;

    void'($urandom(32'h0BAD5EED));
    rst_n = 1'b0; tick = 1'b1; gpio = '0; codes = '0;
    reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);

    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    for (int i = 0; i < NCH; i++) begin
      reg_idx = 2'(i); #1;
      chk(reg_rdata == 8'h00, "R1 control byte after reset", reg_rdata, 0);
    end

    // R2: write and read back
    for (int i = 0; i < NCH; i++) wr(i, 8'(8'h5A ^ (i * 8'h37)));
    for (int i = 0; i < NCH; i++) begin
      reg_idx = 2'(i); #1;
      chk(reg_rdata == 8'(8'h5A ^ (i * 8'h37)), "R2 readback", reg_rdata, 8'(8'h5A ^ (i * 8'h37)));
    end
    chk(out_valid == 1'b0, "R2 writes emit nothing", out_valid, 0);
    for (int i = 0; i < NCH; i++) wr(i, 8'h00);

    // R3/R4: random press/release sequences under random ready
    for (int it = 0; it < 10; it++) begin
      ch   = $urandom % NCH;
      cfg  = 8'($urandom);
      code = 8'(($urandom % 8'h7E) + 1);
      rdy_mode = 2;
      wr(ch, cfg);
      codes[ch*8 +: 8] = code;
      gpio[ch] = 1'b1;
      cycles(40);
      gpio[ch] = 1'b0;
      cycles(60);
      push_exp(0, cfg, code);
      push_exp(2, cfg, code);
      compare_stream("R3 R4 press release");
      wr(ch, 8'h00);
    end

    // Directed: all prefixes
    rdy_mode = 2;
    wr(0, 8'hF0); codes[7:0] = 8'h1C;
    gpio[0] = 1'b1; cycles(40); gpio[0] = 1'b0; cycles(60);
    push_exp(0, 8'hF0, 8'h1C); push_exp(2, 8'hF0, 8'h1C);
    compare_stream("R3 R4 all prefixes");
    wr(0, 8'h00);

    // R6/R7 typematic timing and R5 content
    typematic(2, 8'h94, 8'h1E, 500, 33, "R6 first repeat delay code1", "R7 fast repeat gap");
    typematic(1, 8'h01, 8'h30, 250, 100, "R6 first repeat delay code0", "R7 slow repeat gap");

    // R8 priority and R9 hold
    rdy_mode = 0;
    wr(1, 8'hE0); wr(3, 8'h00);
    codes[15:8] = 8'h05; codes[31:24] = 8'h07;
    gpio[1] = 1'b1; gpio[3] = 1'b1;
    cycles(3);
    chk(out_valid == 1'b1, "R9 valid while stalled", out_valid, 1);
    chk(out_data == 8'h1D, "R8 lowest channel first", out_data, 8'h1D);
    hold_b = out_data;
    for (int i = 0; i < 6; i++) begin
      cycles(1);
      chk(out_valid == 1'b1 && out_data == hold_b, "R9 byte held", out_data, hold_b);
    end
    rdy_mode = 2;
    cycles(50);
    gpio[1] = 1'b0; gpio[3] = 1'b0;
    cycles(80);
    push_exp(0, 8'hE0, 8'h05); push_exp(0, 8'h00, 8'h07);
    push_exp(2, 8'hE0, 8'h05); push_exp(2, 8'h00, 8'h07);
    compare_stream("R8 priority order");
    wr(1, 8'h00);

    // R10: stalls extend a pending delay
    rdy_mode = 1;
    wr(0, 8'h00); wr(1, 8'h0C);
    codes[7:0] = 8'h11; codes[15:8] = 8'h22;
    stall_cnt = 0;
    gpio[0] = 1'b1;
    cycles(20);
    rdy_mode = 0;
    gpio[1] = 1'b1;
    cycles(60);
    rdy_mode = 1;
    wait_count(8'h11, 2);
    gpio[0] = 1'b0; gpio[1] = 1'b0;
    cycles(40);
    st = int'(stall_cnt);
    chk(st > 0, "R10 stall observed", st, 1);
    ta = time_of(8'h11, 0); tb = time_of(8'h11, 1);
    chk(int'(tb - ta) == 252 + st, "R10 delay paused by stall", int'(tb - ta), 252 + st);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h11);
    exp_q.push_back(8'h91); exp_q.push_back(8'hA2);
    compare_stream("R10 stream");
    wr(1, 8'h00);
    cycles(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule